// File: doc/BRIEF.md
# Line Supervision Debounce and Interrupt

This block cleans up the supervision signals of four subscriber line channels and reports them to a host. Each channel has two detector lines. The first line passes through a fixed-period debounce stage, and its period is set in milliseconds. The second line passes through a ground-key filter. This filter is an up/down counter with hysteresis that samples the line at a programmable interval. The filter can be switched off, and it freezes while its channel is inactive.

The filtered bits make up an 8-bit status word. The host reads this word. A shadow copy holds the value the host saw at its last read. An active-low interrupt is driven whenever any unmasked status bit differs from that copy. A read strobe copies the word into the shadow and releases the interrupt.

Debounce stage states: `DB_IDLE` means the output equals the input. `DB_COUNT` means a difference is being timed. Its transitions are: IDLE→COUNT when the input differs and the period is non-zero; COUNT→IDLE when the input returns to the output value, or when the period expires and the output is updated. Ground-key states: `GK_LOW` and `GK_HIGH`. The transition LOW→HIGH happens when the counter reaches 6, and HIGH→LOW when it reaches 0. When the filter is disabled, the state copies the raw line.

Top module: `line_sup_top`

## Requirements
- R1: After reset, status is 0, irq_n is 1, and the debounce period register holds 8 ms.
- R2: With debounce period P from 1 to 15, a change on a first-detector line appears in status on the P-th tick_ms pulse after the change, and not before.
- R3: If the first-detector line returns to the output value before the period expires, the timing is abandoned. A later change starts a fresh count of P ticks.
- R4: With period 0, the first-detector line reaches status one clock after it changes.
- R5: With the ground-key filter enabled, each sample moves a counter up (line high) or down (line low), saturating at 0 and 6. The bit goes to 1 when the counter reaches 6 and to 0 when it reaches 0. Between these values the bit keeps its state.
- R6: With sample interval I, the ground-key filter samples on every (I+1)-th tick_ms pulse. The tick divider starts from 0 at reset.
- R7: With the ground-key filter disabled on an active channel, the second-detector bit follows the raw line one clock later.
- R8: While chan_act for a channel is 0, the channel's second-detector bit holds its value.
- R9: status bit 2c is the debounced first detector of channel c, and bit 2c+1 is the second-detector bit of channel c.
- R10: irq_n is 0 exactly when some status bit with its irq_mask bit set differs from the last-read shadow. Bits whose mask bit is clear have no effect.
- R11: A stat_rd pulse copies status into the shadow. If status does not change, irq_n is 1 in the following cycle.
- R12: A dbnc_wr pulse loads dbnc_val into the debounce period register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| det_a | input | 4 | First detector line per channel |
| det_b | input | 4 | Second detector line per channel |
| chan_act | input | 4 | Channel active flags |
| gk_en | input | 4 | Ground-key filter enable per channel |
| gk_ivl | input | 4 | Ground-key sample interval |
| dbnc_wr | input | 1 | Load strobe for the debounce period |
| dbnc_val | input | 4 | New debounce period in ms |
| irq_mask | input | 8 | Per-bit interrupt enable |
| stat_rd | input | 1 | Host read strobe for status |
| status | output | 8 | Filtered supervision word |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle, assertions check the following: the debounce output only ever moves to the current input value; a zero period passes the input straight through; the ground-key counter stays within 0 to 6 and the bit rises only at the top count; an inactive channel freezes its bit; and a read of a steady word releases the interrupt. Only the bench's scenarios can show the exact tick counts: the P ticks of the debounce, the restart after a bounce, the 6·(I+1) tick latency of the ground-key filter and its hysteresis. The bench also shows the reset period of 8 ms, the bit positions in the status word, and the masking of the interrupt.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
    typedef enum logic { DB_IDLE, DB_COUNT } db_state_t;
    typedef enum logic { GK_LOW, GK_HIGH } gk_state_t;
    localparam int GK_TOP = 6;
endpackage

// File: rtl/sup_debounce.sv
`timescale 1ns/1ps
module sup_debounce
    import sup_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [PW-1:0] per_i,
    input  logic          raw_i,
    output logic          out_o
);
    db_state_t     state_q, state_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic          out_q, out_d;
    logic          run_q;
    logic          expire;

    assign expire = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            cnt_q   <= '0;
            out_q   <= 1'b0;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
            run_q   <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        unique case (state_q)
            DB_IDLE: begin
                if (raw_i != out_q) begin
                    if (per_i == '0) begin
                        out_d = raw_i;
                    end else begin
                        state_d = DB_COUNT;
                        cnt_d   = '0;
                    end
                end
            end
            DB_COUNT: begin
                if (raw_i == out_q) begin
                    state_d = DB_IDLE;
                end else if (per_i == '0) begin
                    out_d   = raw_i;
                    state_d = DB_IDLE;
                end else if (tick_i) begin
                    if (expire) begin
                        out_d   = raw_i;
                        state_d = DB_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = DB_IDLE;
        endcase
    end

    assign out_o = out_q;

    AST_DB_TOWARD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (out_q != $past(out_q))) |-> (out_q == $past(raw_i))); // R2
    AST_DB_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(per_i) == '0) |-> (out_q == $past(raw_i))); // R4
endmodule

// File: rtl/sup_gk_filter.sv
`timescale 1ns/1ps
module sup_gk_filter
    import sup_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [IW-1:0] ivl_i,
    input  logic          en_i,
    input  logic          act_i,
    input  logic          raw_i,
    output logic          out_o
);
    gk_state_t     state_q, state_d;
    logic [IW-1:0] div_q, div_d;
    logic [2:0]    cnt_q, cnt_d;
    logic          run_q;
    logic          samp;

    assign samp = tick_i && (div_q >= ivl_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GK_LOW;
            div_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            div_q   <= div_d;
            cnt_q   <= cnt_d;
            run_q   <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        div_d   = div_q;
        cnt_d   = cnt_q;
        if (act_i) begin
            if (!en_i) begin
                state_d = raw_i ? GK_HIGH : GK_LOW;
            end else if (tick_i) begin
                div_d = samp ? '0 : div_q + 1'b1;
                if (samp) begin
                    if (raw_i) cnt_d = (cnt_q == 3'(GK_TOP)) ? cnt_q : cnt_q + 1'b1;
                    else       cnt_d = (cnt_q == 3'd0) ? cnt_q : cnt_q - 1'b1;
                    unique case (state_q)
                        GK_LOW:  if (cnt_d == 3'(GK_TOP)) state_d = GK_HIGH;
                        GK_HIGH: if (cnt_d == 3'd0)       state_d = GK_LOW;
                        default: state_d = GK_LOW;
                    endcase
                end
            end
        end
    end

    assign out_o = (state_q == GK_HIGH);

    AST_GK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 3'(GK_TOP)); // R5
    AST_GK_RISE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $rose(out_o) && $past(en_i)) |-> (cnt_q == 3'(GK_TOP))); // R5
    AST_GK_HOLD_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(act_i)) |-> $stable(out_o)); // R8
endmodule

// File: rtl/sup_irq.sv
`timescale 1ns/1ps
module sup_irq #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] status_i,
    input  logic [SW-1:0] mask_i,
    input  logic          rd_i,
    output logic          irq_n_o
);
    logic [SW-1:0] shadow_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            run_q    <= 1'b0;
        end else begin
            if (rd_i) shadow_q <= status_i;
            run_q <= 1'b1;
        end
    end

    assign irq_n_o = ~|((status_i ^ shadow_q) & mask_i);

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(rd_i) && $stable(status_i)) |-> irq_n_o); // R11
endmodule

// File: rtl/line_sup_top.sv
`timescale 1ns/1ps
module line_sup_top #(
    parameter int NCH      = 4,
    parameter int DW       = 4,
    parameter int GW       = 4,
    parameter int DBNC_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic [NCH-1:0]   det_a,
    input  logic [NCH-1:0]   det_b,
    input  logic [NCH-1:0]   chan_act,
    input  logic [NCH-1:0]   gk_en,
    input  logic [GW-1:0]    gk_ivl,
    input  logic             dbnc_wr,
    input  logic [DW-1:0]    dbnc_val,
    input  logic [2*NCH-1:0] irq_mask,
    input  logic             stat_rd,
    output logic [2*NCH-1:0] status,
    output logic             irq_n
);
    localparam int SW = 2 * NCH;

    logic [DW-1:0]  dbnc_q;
    logic [NCH-1:0] a_filt, b_filt;

    always_ff @(posedge clk) begin
        if (!rst_n)       dbnc_q <= DW'(DBNC_RST);
        else if (dbnc_wr) dbnc_q <= dbnc_val;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sup_debounce #(.PW(DW)) u_deb (
            .clk(clk), .rst_n(rst_n), .tick_i(tick_ms),
            .per_i(dbnc_q), .raw_i(det_a[c]), .out_o(a_filt[c])
        );
        sup_gk_filter #(.IW(GW)) u_gk (
            .clk(clk), .rst_n(rst_n), .tick_i(tick_ms), .ivl_i(gk_ivl),
            .en_i(gk_en[c]), .act_i(chan_act[c]), .raw_i(det_b[c]),
            .out_o(b_filt[c])
        );
        assign status[2*c]   = a_filt[c];
        assign status[2*c+1] = b_filt[c];
    end

    sup_irq #(.SW(SW)) u_irq (
        .clk(clk), .rst_n(rst_n), .status_i(status),
        .mask_i(irq_mask), .rd_i(stat_rd), .irq_n_o(irq_n)
    );
endmodule

// File: tb/line_sup_top_tb.sv
`timescale 1ns/1ps
module line_sup_top_tb;
    logic       clk = 1'b0;
    logic       rst_n, tick_ms, dbnc_wr, stat_rd;
    logic [3:0] det_a, det_b, chan_act, gk_en, gk_ivl, dbnc_val;
    logic [7:0] irq_mask, status;
    logic       irq_n;
    int vecs = 0;
    int errs = 0;
    bit done = 0;

    always #5 clk = ~clk;

    line_sup_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .det_a(det_a), .det_b(det_b),
        .chan_act(chan_act), .gk_en(gk_en), .gk_ivl(gk_ivl), .dbnc_wr(dbnc_wr),
        .dbnc_val(dbnc_val), .irq_mask(irq_mask), .stat_rd(stat_rd),
        .status(status), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1; @(negedge clk);
            tick_ms = 1'b0; @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_ms = 0; dbnc_wr = 0; stat_rd = 0;
        det_a = 0; det_b = 0; chan_act = 4'hF; gk_en = 0; gk_ivl = 0;
        dbnc_val = 0; irq_mask = 8'h00;
        idle(3); rst_n = 1'b1; idle(1);
    endtask

    task automatic set_period(input logic [3:0] p);
        dbnc_val = p; dbnc_wr = 1'b1; @(negedge clk); dbnc_wr = 1'b0; idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        // R1 reset state and default 8 ms period
        do_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        det_a[1] = 1'b1; idle(2);
        tick(7);
        chk("R1 period8 early", status, 8'h00);
        tick(1);
        chk("R1 period8 done", status, 8'h04);

        // R2 R4 R12 R9 sweep of all periods over rotating channels
        for (int p = 0; p < 16; p++) begin
            int c = p % 4;
            do_reset();
            set_period(4'(p));
            det_a[c] = 1'b1;
            if (p == 0) begin
                @(negedge clk);
                chk("R4 zero period", status, 8'(1 << (2*c)));
            end else begin
                idle(2);
                tick(p - 1);
                chk("R2 before expiry", status, 8'h00);
                tick(1);
                chk("R2 R9 R12 at expiry", status, 8'(1 << (2*c)));
                det_a[c] = 1'b0; idle(2);
                tick(p);
                chk("R2 falling", status, 8'h00);
            end
        end

        // R3 bounce restarts the count
        do_reset(); set_period(4'd5);
        det_a[0] = 1'b1; idle(2); tick(3);
        det_a[0] = 1'b0; idle(2);
        det_a[0] = 1'b1; idle(2); tick(4);
        chk("R3 restart early", status, 8'h00);
        tick(1);
        chk("R3 restart done", status, 8'h01);

        // R5 R6 ground-key latency over intervals
        for (int iv = 0; iv < 4; iv++) begin
            do_reset();
            gk_ivl = 4'(iv); gk_en[3] = 1'b1; det_b[3] = 1'b1;
            tick(6*(iv+1) - 1);
            chk("R6 rise early", status, 8'h00);
            tick(1);
            chk("R5 R6 rise", status, 8'h80);
            det_b[3] = 1'b0;
            tick(6*(iv+1) - 1);
            chk("R6 fall early", status, 8'h80);
            tick(1);
            chk("R5 R6 fall", status, 8'h00);
        end

        // R5 hysteresis: partial count does not switch
        do_reset(); gk_en[2] = 1'b1; det_b[2] = 1'b1;
        tick(5); det_b[2] = 1'b0; tick(5);
        chk("R5 hysteresis low", status, 8'h00);
        det_b[2] = 1'b1; tick(6);
        chk("R5 reach top", status, 8'h20);
        det_b[2] = 1'b0; tick(3); det_b[2] = 1'b1; tick(2);
        chk("R5 hysteresis high", status, 8'h20);

        // R7 disabled tracking, R8 inactive hold
        do_reset();
        det_b[1] = 1'b1; @(negedge clk);
        chk("R7 track high", status, 8'h08);
        det_b[1] = 1'b0; @(negedge clk);
        chk("R7 track low", status, 8'h00);
        chan_act[1] = 1'b0; det_b[1] = 1'b1; idle(4);
        chk("R8 hold inactive", status, 8'h00);
        chan_act[1] = 1'b1; @(negedge clk);
        chk("R8 resume", status, 8'h08);

        // R10 R11 interrupt
        do_reset(); set_period(4'd0);
        irq_mask = 8'h01;
        det_a[1] = 1'b1; idle(2);
        chk("R10 masked bit", {7'd0, irq_n}, 8'h01);
        irq_mask = 8'h04; @(negedge clk);
        chk("R10 unmasked diff", {7'd0, irq_n}, 8'h00);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        chk("R11 read releases", {7'd0, irq_n}, 8'h01);
        det_a[1] = 1'b0; idle(2);
        chk("R10 return differs", {7'd0, irq_n}, 8'h00);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        chk("R11 second read", {7'd0, irq_n}, 8'h01);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule